// File: doc/BRIEF.md
# Stalling Byte FIFO Port Bridge

This block sits between an 8-bit coprocessor core and two byte streams. Each stream has a 16-entry queue: the inbound queue is filled by a host through a valid/ready stream and read by the core, and the outbound queue is written by the core and drained by the host through a second valid/ready stream. The core reaches both queues through three addresses in its port space. A blocking address, a non-blocking address and a status address are the three choices, so picoware can decide whether an empty or full queue should stall it, return a null result, or first be inspected.

A blocking access that cannot complete is latched inside the bridge and raises `halt`. The core must freeze while `halt` is high, and the bridge ignores any strobe presented in that time. Once the queue condition clears, the latched access is carried out once and `halt` drops. Stream rules: a host byte is taken on any clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is low whenever the inbound queue is full. `out_valid` is high whenever the outbound queue holds a byte, and `out_data` shows the oldest byte. That byte leaves on an edge where `out_ready` is also high. A host may hold `out_ready` high indefinitely.

Top module: `fifo_port_bridge`

## Requirements
- R1: Each queue holds at most 16 bytes in arrival order. `in_ready` is low exactly when the inbound queue holds 16 bytes. `out_valid` is high exactly when the outbound queue is non-empty, and bytes leave on the outbound stream in the order they were written.
- R2: Port map: address 0x00 is blocking data, 0x01 is non-blocking data, and 0x02 is status. A status read returns bit0 = inbound queue empty, bit1 = outbound queue full, and zero in all other bits. `rd_data` is registered and valid in the cycle after the read strobe.
- R3: A blocking read (0x00) of an empty inbound queue raises `halt` in the cycle after the strobe. `halt` stays high while the queue is empty. It falls in the cycle after the first byte lands, and in that same cycle `rd_data` shows that byte, which has been removed once.
- R4: A blocking write (0x00) to a full outbound queue raises `halt` until a byte leaves. `halt` falls one cycle after that departure, and the written byte is stored once, behind the bytes already queued.
- R5: A non-blocking read (0x01) of an empty inbound queue returns 0x00 and leaves the queue unchanged. On a non-empty queue it returns and removes the oldest byte.
- R6: A non-blocking write (0x01) to a full outbound queue is discarded.
- R7: Status reads and non-blocking accesses never raise `halt`.
- R8: While `halt` is high, read and write strobes are ignored, and `rd_data` holds its value.
- R9: A push and a pop on the same queue in the same cycle are both honoured, and the occupancy stays the same.
- R10: Reads of unmapped addresses (0x03 to 0xFF) return 0x00. Writes to any address other than 0x00 and 0x01 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_addr | input | 8 | Core port address |
| rd_stb | input | 1 | Core read strobe, one cycle per access |
| wr_stb | input | 1 | Core write strobe, one cycle per access |
| wr_data | input | 8 | Core write byte |
| rd_data | output | 8 | Registered read result |
| halt | output | 1 | Freeze request to the core |
| in_valid | input | 1 | Host inbound byte valid |
| in_ready | output | 1 | Inbound queue can accept |
| in_data | input | 8 | Host inbound byte |
| out_valid | output | 1 | Outbound byte available |
| out_ready | input | 1 | Host takes outbound byte |
| out_data | output | 8 | Oldest outbound byte |

## Verification
The assertions check the following on every cycle:
- queue occupancy bounds and `in_ready` back-pressure at the full mark;
- `out_valid` against occupancy;
- that non-blocking and status accesses never stall;
- that `rd_data` is frozen during a stall;
- that a simultaneous push and pop leaves occupancy unchanged.

Only the bench scenarios can show the following:
- the byte values returned and their order;
- the exact release cycle of `halt`;
- that a stalled access completes exactly once;
- that discarded writes and strobes given during a stall leave no trace in either queue.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] PA_BLOCK  = 8'h00;
  localparam logic [ADDR_W-1:0] PA_NOWAIT = 8'h01;
  localparam logic [ADDR_W-1:0] PA_STATUS = 8'h02;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_WAIT_RD = 2'd1,
    ST_WAIT_WR = 2'd2
  } stall_e;
endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign head    = slots[rptr];

  always_ff @(posedge clk) begin
    if (do_push) slots[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/port_access_ctrl.sv
module port_access_ctrl
  import bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              in_empty,
  input  logic [DATA_W-1:0] in_head,
  input  logic              out_full,
  output logic              in_pop,
  output logic              out_push,
  output logic [DATA_W-1:0] out_push_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              halt
);
  stall_e            state;
  logic [DATA_W-1:0] held_byte;
  logic              take_rd, take_wr, is_blk, is_nb;

  assign take_rd = (state == ST_RUN) && rd_stb;
  assign take_wr = (state == ST_RUN) && wr_stb && !rd_stb;
  assign is_blk  = (port_addr == PA_BLOCK);
  assign is_nb   = (port_addr == PA_NOWAIT);
  assign halt    = (state != ST_RUN);

  always_comb begin
    in_pop = 1'b0;
    if (!in_empty) begin
      if (take_rd && (is_blk || is_nb)) in_pop = 1'b1;
      if (state == ST_WAIT_RD)          in_pop = 1'b1;
    end
    out_push = 1'b0;
    if (!out_full) begin
      if (take_wr && (is_blk || is_nb)) out_push = 1'b1;
      if (state == ST_WAIT_WR)          out_push = 1'b1;
    end
    out_push_data = (state == ST_WAIT_WR) ? held_byte : wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      held_byte <= '0;
      rd_data   <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (take_rd) begin
            if (is_blk) begin
              if (in_empty) state <= ST_WAIT_RD;
              else          rd_data <= in_head;
            end else if (is_nb) begin
              rd_data <= in_empty ? '0 : in_head;
            end else if (port_addr == PA_STATUS) begin
              rd_data <= {{(DATA_W-2){1'b0}}, out_full, in_empty};
            end else begin
              rd_data <= '0;
            end
          end else if (take_wr && is_blk && out_full) begin
            state     <= ST_WAIT_WR;
            held_byte <= wr_data;
          end
        end
        ST_WAIT_RD: begin
          if (!in_empty) begin
            rd_data <= in_head;
            state   <= ST_RUN;
          end
        end
        ST_WAIT_WR: begin
          if (!out_full) state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/fifo_port_bridge.sv
module fifo_port_bridge
  import bridge_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  port_addr,
  input  logic        rd_stb,
  input  logic        wr_stb,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  output logic        halt,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data
);
  logic              in_empty, in_full, in_pop;
  logic              out_empty, out_full, out_push;
  logic [DATA_W-1:0] in_head, out_push_data;
  logic [CNT_W-1:0]  in_cnt, out_cnt;

  assign in_ready  = !in_full;
  assign out_valid = !out_empty;

  byte_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_inq (
    .clk(clk), .rst_n(rst_n),
    .push(in_valid && in_ready), .push_data(in_data),
    .pop(in_pop), .head(in_head),
    .empty(in_empty), .full(in_full), .count(in_cnt)
  );

  byte_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_outq (
    .clk(clk), .rst_n(rst_n),
    .push(out_push), .push_data(out_push_data),
    .pop(out_valid && out_ready), .head(out_data),
    .empty(out_empty), .full(out_full), .count(out_cnt)
  );

  port_access_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .port_addr(port_addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .in_empty(in_empty), .in_head(in_head), .out_full(out_full),
    .in_pop(in_pop), .out_push(out_push), .out_push_data(out_push_data),
    .rd_data(rd_data), .halt(halt)
  );
endmodule

// File: rtl/fifo_port_bridge_checker.sv
module fifo_port_bridge_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       port_addr,
  input logic             rd_stb,
  input logic             wr_stb,
  input logic [7:0]       rd_data,
  input logic             halt,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_pop,
  input logic [CNT_W-1:0] in_cnt,
  input logic             out_valid,
  input logic [CNT_W-1:0] out_cnt
);
  assert_in_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt <= CNT_W'(DEPTH));

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt == CNT_W'(DEPTH)) |-> !in_ready);

  assert_out_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (out_cnt != '0));

  assert_nb_no_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && (rd_stb || wr_stb) && port_addr != 8'h00) |=> !halt);

  assert_hold_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && $past(halt)) |-> $stable(rd_data));

  assert_keep_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_pop) |=> $stable(in_cnt));
endmodule

bind fifo_port_bridge fifo_port_bridge_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .rd_data(rd_data), .halt(halt), .in_valid(in_valid), .in_ready(in_ready),
  .in_pop(in_pop), .in_cnt(in_cnt), .out_valid(out_valid), .out_cnt(out_cnt)
);

// File: tb/fifo_port_bridge_bench.sv
module fifo_port_bridge_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] port_addr = '0;
  logic       rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       halt;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_port_bridge u_fifo_port_bridge (
    .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data), .halt(halt), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  // Row: {is_write, addr, data, expected read}; read rows are checked.
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 8'h02, 8'h00, 8'h01},  // R2 status: inbound empty
    {1'b0, 8'h01, 8'h00, 8'h00},  // R5 non-blocking read of empty
    {1'b1, 8'h01, 8'hA5, 8'h00},  // R2 non-blocking write
    {1'b1, 8'h01, 8'h3C, 8'h00},  // R2 non-blocking write
    {1'b0, 8'h02, 8'h00, 8'h01},  // R2 status unchanged
    {1'b1, 8'h05, 8'h77, 8'h00},  // R10 unmapped write
    {1'b0, 8'h07, 8'h00, 8'h00},  // R10 unmapped read
    {1'b1, 8'h02, 8'h55, 8'h00}   // R10 write to status ignored
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic core_rd(input logic [7:0] a);
    @(negedge clk); port_addr = a; rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic core_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); port_addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic host_push(input logic [7:0] d);
    @(negedge clk); in_data = d; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic host_pop(input string req, input logic [7:0] exp);
    @(negedge clk);
    check(req, {7'd0, out_valid}, 8'h01);
    check(req, out_data, exp);
    out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check("R1 reset in_ready", {7'd0, in_ready}, 8'h01);
    check("R1 reset out_valid", {7'd0, out_valid}, 8'h00);
    check("R3 reset halt", {7'd0, halt}, 8'h00);
    check("R2 reset rd_data", rd_data, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      if (VEC[i][24]) core_wr(VEC[i][23:16], VEC[i][15:8]);
      else begin
        core_rd(VEC[i][23:16]);
        check("R2/R5/R10 table read", rd_data, VEC[i][7:0]);
      end
      check("R7 table no halt", {7'd0, halt}, 8'h00);
    end
    host_pop("R1 order first", 8'hA5);
    host_pop("R1 order second", 8'h3C);
    check("R10 ignored writes absent", {7'd0, out_valid}, 8'h00);

    // basic reads from inbound queue
    host_push(8'h11); host_push(8'h22);
    core_rd(8'h00); check("R3 blocking read ready data", rd_data, 8'h11);
    core_rd(8'h01); check("R5 non-blocking read", rd_data, 8'h22);
    core_rd(8'h01); check("R5 empty read gives zero", rd_data, 8'h00);
    core_rd(8'h02); check("R5 still empty", rd_data, 8'h01);

    // fill inbound to capacity
    for (int i = 0; i < 16; i++) host_push(8'(i + 8'h80));
    check("R1 in_ready low when full", {7'd0, in_ready}, 8'h00);
    host_push(8'hEE);
    for (int i = 0; i < 16; i++) begin
      core_rd(8'h01); check("R1 inbound order", rd_data, 8'(i + 8'h80));
    end
    core_rd(8'h02); check("R1 overflow byte dropped", rd_data, 8'h01);

    // blocking read stall
    core_rd(8'h00);
    check("R3 halt raised", {7'd0, halt}, 8'h01);
    core_wr(8'h01, 8'h99);
    repeat (2) @(negedge clk);
    check("R3 halt held while empty", {7'd0, halt}, 8'h01);
    in_data = 8'h5A; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    check("R3 halt still high on arrival", {7'd0, halt}, 8'h01);
    @(negedge clk);
    check("R3 halt released", {7'd0, halt}, 8'h00);
    check("R3 stalled read data", rd_data, 8'h5A);
    core_rd(8'h02); check("R3 consumed once", rd_data, 8'h01);
    check("R8 write during halt ignored", {7'd0, out_valid}, 8'h00);

    // blocking write stall
    for (int i = 0; i < 16; i++) core_wr(8'h01, 8'(i + 1));
    core_rd(8'h02); check("R2 status full", rd_data, 8'h03);
    core_wr(8'h01, 8'hEE);
    check("R7 nb write full no halt", {7'd0, halt}, 8'h00);
    core_wr(8'h00, 8'hCD);
    check("R4 halt raised", {7'd0, halt}, 8'h01);
    @(negedge clk);
    check("R4 halt held while full", {7'd0, halt}, 8'h01);
    out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    check("R4 halt high at departure", {7'd0, halt}, 8'h01);
    @(negedge clk);
    check("R4 halt released", {7'd0, halt}, 8'h00);
    for (int i = 1; i < 16; i++) host_pop("R4 R6 drain order", 8'(i + 1));
    host_pop("R4 stalled byte once", 8'hCD);
    check("R6 discarded byte absent", {7'd0, out_valid}, 8'h00);

    // simultaneous push and pop
    host_push(8'h40);
    @(negedge clk); in_data = 8'h41; in_valid = 1'b1; port_addr = 8'h01; rd_stb = 1'b1;
    @(negedge clk); in_valid = 1'b0; rd_stb = 1'b0;
    check("R9 pop value", rd_data, 8'h40);
    core_rd(8'h02); check("R9 one byte left", rd_data, 8'h00);
    core_rd(8'h01); check("R9 pushed byte kept", rd_data, 8'h41);
    core_rd(8'h02); check("R9 then empty", rd_data, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule